// File: doc/BRIEF.md
# Receiver-Detect Termination Controller

This block decides, for each lane of a repeater, when the receive input stops presenting high impedance and turns on its 50 ohm termination. In its two automatic modes it asks the analog detect circuit to probe the far end with a one-cycle strobe. The strobes repeat on a fixed timer. In the bounded mode the search gives up after a set number of tries. In the unbounded mode it keeps probing until a receiver answers. Two forced modes hold the input at high impedance or at 50 ohm without probing.

A shared power-down pin switches off the termination and the output drivers whenever it is high. The pin also clears every lane's search, but only when it stays high for a minimum number of cycles. A register override can take over this reset from the pin. A second override lets each lane take its mode from its own register field instead of the shared mode pins. All timing constants are parameters given in clock cycles.

Top module: `rxdet_term_ctrl`

## Requirements
- R1: In mode 2'b00 a lane never probes, its termination enable stays 0 and its status reads idle (2'b00).
- R2: In modes 2'b01 and 2'b10 a searching lane raises its probe output for exactly one cycle every INTERVAL_CYC cycles. The first probe appears INTERVAL_CYC cycles after the search starts.
- R3: In mode 2'b01, once MAX_TRIES probes have all failed, probing stops. The status then reads timed out (2'b11) and the termination stays off.
- R4: In mode 2'b10, probing continues beyond MAX_TRIES attempts while no receiver answers, and the status reads searching (2'b01).
- R5: If rx_present is high for a lane during its probe cycle, then on the next cycle the termination enable is 1, the status reads detected (2'b10) and probing stops.
- R6: In mode 2'b11 the termination enable is 1 one cycle later, with no probing and an idle status.
- R7: While the effective power-down is high, the termination enable, the probes and drv_en are all 0 from the next cycle on, and every lane's timer is frozen.
- R8: If pd_in stays high for HOLD_CYC or more consecutive cycles, every lane is cleared. After release, the search starts again from attempt zero, and the first probe comes INTERVAL_CYC cycles after pd_in falls.
- R9: A pd_in pulse shorter than HOLD_CYC clears nothing. A lane that had detected a receiver turns its termination back on one cycle after release.
- R10: While rst_ovr_en is 1, pd_in has no effect. Instead, rst_ovr_val acts as both power-down and reset, with no minimum hold time.
- R11: While mode_ovr_en is 1, lane n takes its mode from mode_reg[2n+1:2n] instead of from mode_pin.
- R12: When a lane's effective mode changes, the lane restarts from the initial state of the new mode. In an automatic mode, that means searching with the termination off.
- R13: During the synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_in | input | 1 | Power-down pin; held high long enough, it clears all lanes |
| rst_ovr_en | input | 1 | Register bit: take power-down and reset from rst_ovr_val |
| rst_ovr_val | input | 1 | Register bit: power-down and reset value used under override |
| mode_pin | input | 2 | Shared termination mode from the pins |
| mode_ovr_en | input | 1 | Register bit: take each lane's mode from mode_reg |
| mode_reg | input | 2*NUM_CH | Per-lane mode fields, lane n at bits 2n+1:2n |
| rx_present | input | NUM_CH | Detect result per lane, sampled in the probe cycle |
| term_en | output | NUM_CH | 1 = 50 ohm termination on, 0 = high impedance |
| probe | output | NUM_CH | One-cycle receiver-detect probe request |
| status | output | 2*NUM_CH | Per lane: 00 idle, 01 searching, 10 detected, 11 timed out |
| drv_en | output | 1 | Output driver enable; 0 while powered down |

## Verification
Each lane's termination, probe and status are registered. They react to an input on the first clock edge after it, and drv_en follows the effective power-down with the same one-cycle delay. A search, or a restart after a long power-down, produces its first probe INTERVAL_CYC edges later. A pin clear takes effect on the HOLD_CYC-th consecutive high sample. The bench's behavioural model steps on the same edge as the design and is compared two nanoseconds after every rising edge. The directed checks wait whole cycles counted from the negative edge on which the stimulus was driven, including an exact count of cycles from release to the first probe.

// File: rtl/rxdet_pkg.sv
`timescale 1ns/1ps
package rxdet_pkg;
  typedef enum logic [1:0] {
    MD_HIZ      = 2'b00,
    MD_AUTO_LIM = 2'b01,
    MD_AUTO_INF = 2'b10,
    MD_TERM50   = 2'b11
  } rxd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SEARCH = 2'b01,
    ST_FOUND  = 2'b10,
    ST_GIVEUP = 2'b11
  } rxd_stat_e;
endpackage

// File: rtl/rxdet_pd_qual.sv
`timescale 1ns/1ps
module rxdet_pd_qual #(
  parameter int HOLD_CYC = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_in,
  input  logic ovr_en,
  input  logic ovr_val,
  output logic gate_o,
  output logic clr_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_MAX  = HW'(HOLD_CYC);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) hold_cnt <= '0;
    else if (pd_in) hold_cnt <= (hold_cnt == HOLD_MAX) ? hold_cnt : hold_cnt + 1'b1;
    else hold_cnt <= '0;
  end

  assign gate_o = ovr_en ? ovr_val : pd_in;
  assign clr_o  = ovr_en ? ovr_val : (pd_in && (hold_cnt >= HOLD_LAST));

  // R8
  hold_range_chk: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= HOLD_MAX);
endmodule

// File: rtl/rxdet_chan.sv
`timescale 1ns/1ps
module rxdet_chan
  import rxdet_pkg::*;
#(
  parameter int INTERVAL_CYC = 1500000,
  parameter int MAX_TRIES    = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gate_i,
  input  logic       clr_i,
  input  logic [1:0] mode_i,
  input  logic       rx_i,
  output logic       term_o,
  output logic       probe_o,
  output logic [1:0] stat_o
);
  localparam int TW = $clog2(INTERVAL_CYC);
  localparam int AW = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(INTERVAL_CYC - 1);
  localparam logic [AW-1:0] ATT_MAX  = AW'(MAX_TRIES);

  logic [1:0]    mode_q;
  logic [TW-1:0] tmr_q, tmr_n;
  logic [AW-1:0] att_q, att_n;
  logic          fnd_q, fnd_n, gu_q, gu_n;
  logic          probe_q, probe_n, term_q, term_n;
  rxd_stat_e     stat_q, stat_n;
  logic          is_auto;

  always_comb begin
    tmr_n   = tmr_q;
    att_n   = att_q;
    fnd_n   = fnd_q;
    gu_n    = gu_q;
    probe_n = 1'b0;
    is_auto = (mode_i == MD_AUTO_LIM) || (mode_i == MD_AUTO_INF);
    if (clr_i || (mode_i != mode_q)) begin
      tmr_n = '0;
      att_n = '0;
      fnd_n = 1'b0;
      gu_n  = 1'b0;
    end else if (!gate_i && is_auto && !fnd_q && !gu_q) begin
      if (probe_q && rx_i) begin
        fnd_n = 1'b1;
      end else if (probe_q && (mode_i == MD_AUTO_LIM) && (att_q == ATT_MAX)) begin
        gu_n = 1'b1;
      end else if (tmr_q == TMR_LAST) begin
        tmr_n   = '0;
        probe_n = 1'b1;
        if (att_q != ATT_MAX) att_n = att_q + 1'b1;
      end else begin
        tmr_n = tmr_q + 1'b1;
      end
    end
    term_n = !gate_i && ((mode_i == MD_TERM50) || (is_auto && fnd_n));
    if (!is_auto)   stat_n = ST_IDLE;
    else if (fnd_n) stat_n = ST_FOUND;
    else if (gu_n)  stat_n = ST_GIVEUP;
    else            stat_n = ST_SEARCH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= mode_i;
      tmr_q   <= '0;
      att_q   <= '0;
      fnd_q   <= 1'b0;
      gu_q    <= 1'b0;
      probe_q <= 1'b0;
      term_q  <= 1'b0;
      stat_q  <= ST_IDLE;
    end else begin
      mode_q  <= mode_i;
      tmr_q   <= tmr_n;
      att_q   <= att_n;
      fnd_q   <= fnd_n;
      gu_q    <= gu_n;
      probe_q <= probe_n;
      term_q  <= term_n;
      stat_q  <= stat_n;
    end
  end

  assign term_o  = term_q;
  assign probe_o = probe_q;
  assign stat_o  = stat_q;

  // R1
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_HIZ) |-> (!term_q && !probe_q && stat_q == ST_IDLE));
  // R2
  probe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    probe_q |=> !probe_q);
  // R3
  giveup_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q == ST_GIVEUP && !clr_i && mode_i == mode_q) |=> (!probe_q && stat_q == ST_GIVEUP));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    att_q <= ATT_MAX);
  // R5
  found_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q == ST_FOUND && !clr_i && mode_i == mode_q) |=> stat_q == ST_FOUND);
  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    gate_i |=> (!term_q && !probe_q));
endmodule

// File: rtl/rxdet_term_ctrl.sv
`timescale 1ns/1ps
module rxdet_term_ctrl #(
  parameter int NUM_CH       = 2,
  parameter int INTERVAL_CYC = 1500000,
  parameter int MAX_TRIES    = 50,
  parameter int HOLD_CYC     = 625
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pd_in,
  input  logic                rst_ovr_en,
  input  logic                rst_ovr_val,
  input  logic [1:0]          mode_pin,
  input  logic                mode_ovr_en,
  input  logic [2*NUM_CH-1:0] mode_reg,
  input  logic [NUM_CH-1:0]   rx_present,
  output logic [NUM_CH-1:0]   term_en,
  output logic [NUM_CH-1:0]   probe,
  output logic [2*NUM_CH-1:0] status,
  output logic                drv_en
);
  logic gate, clr;

  rxdet_pd_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .pd_in   (pd_in),
    .ovr_en  (rst_ovr_en),
    .ovr_val (rst_ovr_val),
    .gate_o  (gate),
    .clr_o   (clr)
  );

  always_ff @(posedge clk) begin
    if (rst) drv_en <= 1'b0;
    else     drv_en <= !gate;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [1:0] mode_eff;
    assign mode_eff = mode_ovr_en ? mode_reg[2*ch +: 2] : mode_pin;

    rxdet_chan #(
      .INTERVAL_CYC (INTERVAL_CYC),
      .MAX_TRIES    (MAX_TRIES)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .gate_i  (gate),
      .clr_i   (clr),
      .mode_i  (mode_eff),
      .rx_i    (rx_present[ch]),
      .term_o  (term_en[ch]),
      .probe_o (probe[ch]),
      .stat_o  (status[2*ch +: 2])
    );
  end

  // R13
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (!drv_en && term_en == '0 && probe == '0));
endmodule

// File: tb/test_rxdet_term_ctrl.sv
`timescale 1ns/1ps
module test_rxdet_term_ctrl;
  localparam int NCH  = 2;
  localparam int IVL  = 8;
  localparam int MAXT = 50;
  localparam int HOLD = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pd_in = 1'b0;
  logic             rst_ovr_en = 1'b0;
  logic             rst_ovr_val = 1'b0;
  logic [1:0]       mode_pin = 2'b00;
  logic             mode_ovr_en = 1'b0;
  logic [2*NCH-1:0] mode_reg = '0;
  logic [NCH-1:0]   rx_present = '0;
  logic [NCH-1:0]   term_en, probe;
  logic [2*NCH-1:0] status;
  logic             drv_en;

  int checks = 0;
  int errors = 0;
  int probes0 = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxdet_term_ctrl #(.NUM_CH(NCH), .INTERVAL_CYC(IVL), .MAX_TRIES(MAXT), .HOLD_CYC(HOLD)) i_rxdet_term_ctrl (
    .clk(clk), .rst(rst), .pd_in(pd_in), .rst_ovr_en(rst_ovr_en), .rst_ovr_val(rst_ovr_val),
    .mode_pin(mode_pin), .mode_ovr_en(mode_ovr_en), .mode_reg(mode_reg), .rx_present(rx_present),
    .term_en(term_en), .probe(probe), .status(status), .drv_en(drv_en)
  );

  // behavioural reference model
  int m_hc, m_drv;
  int m_mode[NCH], m_tmr[NCH], m_att[NCH], m_fnd[NCH], m_gu[NCH], m_pr[NCH], m_term[NCH], m_st[NCH];

  initial begin
    m_hc = 0; m_drv = 0;
    for (int c = 0; c < NCH; c++) begin
      m_mode[c] = 0; m_tmr[c] = 0; m_att[c] = 0; m_fnd[c] = 0;
      m_gu[c] = 0; m_pr[c] = 0; m_term[c] = 0; m_st[c] = 0;
    end
  end

  always @(posedge clk) begin
    int gate, clr, me, auto_m, old_pr;
    if (rst) begin
      m_hc = 0; m_drv = 0;
      for (int c = 0; c < NCH; c++) begin
        m_mode[c] = mode_ovr_en ? int'(mode_reg[2*c +: 2]) : int'(mode_pin);
        m_tmr[c] = 0; m_att[c] = 0; m_fnd[c] = 0; m_gu[c] = 0;
        m_pr[c] = 0; m_term[c] = 0; m_st[c] = 0;
      end
    end else begin
      gate = rst_ovr_en ? int'(rst_ovr_val) : int'(pd_in);
      clr  = rst_ovr_en ? int'(rst_ovr_val) : ((pd_in && m_hc >= HOLD - 1) ? 1 : 0);
      if (pd_in) begin if (m_hc < HOLD) m_hc++; end else m_hc = 0;
      m_drv = gate ? 0 : 1;
      for (int c = 0; c < NCH; c++) begin
        me = mode_ovr_en ? int'(mode_reg[2*c +: 2]) : int'(mode_pin);
        auto_m = (me == 1 || me == 2) ? 1 : 0;
        old_pr = m_pr[c];
        m_pr[c] = 0;
        if (clr != 0 || me != m_mode[c]) begin
          m_tmr[c] = 0; m_att[c] = 0; m_fnd[c] = 0; m_gu[c] = 0;
        end else if (gate == 0 && auto_m != 0 && m_fnd[c] == 0 && m_gu[c] == 0) begin
          if (old_pr != 0 && rx_present[c]) m_fnd[c] = 1;
          else if (old_pr != 0 && me == 1 && m_att[c] == MAXT) m_gu[c] = 1;
          else begin
            m_tmr[c]++;
            if (m_tmr[c] == IVL) begin
              m_tmr[c] = 0; m_pr[c] = 1;
              if (m_att[c] < MAXT) m_att[c]++;
            end
          end
        end
        m_mode[c] = me;
        m_term[c] = (gate == 0 && (me == 3 || (auto_m != 0 && m_fnd[c] != 0))) ? 1 : 0;
        m_st[c] = (auto_m == 0) ? 0 : (m_fnd[c] != 0) ? 2 : (m_gu[c] != 0) ? 3 : 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    chk(int'(drv_en) == m_drv, "R7 drv_en", int'(drv_en), m_drv);
    for (int c = 0; c < NCH; c++) begin
      chk(int'(probe[c]) == m_pr[c], "R2 probe", int'(probe[c]), m_pr[c]);
      chk(int'(term_en[c]) == m_term[c], "R5 term_en", int'(term_en[c]), m_term[c]);
      chk(int'(status[2*c +: 2]) == m_st[c], "R12 status", int'(status[2*c +: 2]), m_st[c]);
    end
    if (probe[0]) probes0++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t: actual 0 expected 1", $time);
      finish_run();
    end
  end

  initial begin
    int snap, k;
    tick(4);
    // R13 outputs quiet in reset
    chk(term_en == '0 && probe == '0 && status == '0 && !drv_en, "R13", int'(term_en), 0);
    rst = 1'b0;
    tick(20);
    // R1 high impedance mode
    chk(term_en[0] == 1'b0 && status[1:0] == 2'b00, "R1", int'(status[1:0]), 0);
    chk(probes0 == 0, "R1 probes", probes0, 0);

    mode_pin = 2'b11;
    tick(3);
    // R6 forced 50 ohm
    chk(term_en == 2'b11, "R6 term", int'(term_en), 3);
    chk(status == 4'b0000, "R6 status", int'(status), 0);

    mode_pin = 2'b01;
    snap = probes0;
    tick(IVL * MAXT + 40);
    // R3 bounded search gives up
    chk(status[1:0] == 2'b11, "R3 status", int'(status[1:0]), 3);
    chk(probes0 - snap == MAXT, "R3 probe count", probes0 - snap, MAXT);
    chk(term_en[0] == 1'b0, "R3 term", int'(term_en[0]), 0);

    mode_pin = 2'b10;
    snap = probes0;
    tick(IVL * (MAXT + 10) + 2);
    // R4 unbounded search continues
    chk(probes0 - snap == MAXT + 10, "R4 probe count", probes0 - snap, MAXT + 10);
    chk(status[1:0] == 2'b01, "R4 status", int'(status[1:0]), 1);

    rx_present[0] = 1'b1;
    tick(IVL + 3);
    // R5 detection
    chk(status[1:0] == 2'b10 && term_en[0], "R5 ch0", int'(status[1:0]), 2);
    chk(status[3:2] == 2'b01 && !term_en[1], "R5 ch1", int'(status[3:2]), 1);

    pd_in = 1'b1;
    tick(2);
    // R7 power-down gating
    chk(!term_en[0] && !drv_en, "R7", int'(term_en[0]), 0);
    tick(1);
    pd_in = 1'b0;
    tick(2);
    // R9 short pulse keeps detection
    chk(status[1:0] == 2'b10 && term_en[0] && drv_en, "R9", int'(status[1:0]), 2);

    rx_present[0] = 1'b0;
    pd_in = 1'b1;
    tick(HOLD + 3);
    pd_in = 1'b0;
    k = 0;
    for (int i = 1; i <= 3 * IVL; i++) begin
      tick(1);
      if (probe[0] && k == 0) k = i;
    end
    // R8 long pulse clears, first probe one interval after release
    chk(k == IVL, "R8 first probe", k, IVL);
    chk(status[1:0] == 2'b01, "R8 status", int'(status[1:0]), 1);

    rx_present[0] = 1'b1;
    tick(IVL + 3);
    rst_ovr_en = 1'b1;
    pd_in = 1'b1;
    tick(HOLD + 5);
    // R10 pin ignored under override
    chk(term_en[0] && drv_en && status[1:0] == 2'b10, "R10 pin ignored", int'(term_en[0]), 1);
    rst_ovr_val = 1'b1;
    tick(1);
    rst_ovr_val = 1'b0;
    tick(1);
    // R10 register reset clears at once
    chk(status[1:0] == 2'b01 && !term_en[0], "R10 clear", int'(status[1:0]), 1);
    pd_in = 1'b0;
    rst_ovr_en = 1'b0;
    tick(2);

    mode_ovr_en = 1'b1;
    mode_reg = 4'b0011;
    tick(3);
    // R11 per-lane register mode
    chk(term_en == 2'b01 && status[3:2] == 2'b00, "R11", int'(term_en), 1);

    mode_ovr_en = 1'b0;
    mode_pin = 2'b10;
    tick(IVL + 4);
    chk(status[1:0] == 2'b10, "R12 setup", int'(status[1:0]), 2);
    mode_pin = 2'b01;
    tick(1);
    // R12 mode change restarts
    chk(status[1:0] == 2'b01 && !term_en[0], "R12", int'(status[1:0]), 1);
    tick(4);

    done = 1;
    finish_run();
  end
endmodule